// File: doc/BRIEF.md
# Display Window Shadow Register Bank

The bank holds the configuration of a set of display overlay windows and hands it to the scan-out pipeline without tearing. Each window has an enable, a pixel format code, a frame buffer base address, a source offset and a screen position. Software writes reach only a shadow copy. The active copy that drives the pipeline changes only on a vertical sync pulse. A window is copied only when a transfer has been requested and the window is not held.

Software uses the hold mask to make a multi-field change in one step. It sets the hold bit of a window, rewrites any number of that window's fields, requests a transfer and then releases the hold. The whole new configuration lands at the first vsync after the release. A window's fields never reach the active copy part by part. Reads always return the shadow copy, so read-modify-write sequences see what software last wrote.

Top module: `wsb_bank`

Address map, with IDX_W = clog2(NUM_WIN) and ADDR_W = IDX_W + 3:
- Window registers: addr[ADDR_W-1] = 0. The window index is addr[IDX_W+1:2] and the field is addr[1:0].
  - Field 0 is control: bit 0 is the enable and bits 3:1 are the format.
  - Field 1 is the base address.
  - Field 2 is the offset, with x in bits 15:0 and y in bits 31:16.
  - Field 3 is the position, laid out the same way as the offset.
- Global registers: addr[ADDR_W-1] = 1.
  - addr[0] = 0 selects the hold mask, one bit per window in bits NUM_WIN-1:0.
  - addr[0] = 1 selects the transfer request at bit 0.

## Requirements
- R1: After reset every active field, every shadow field, the hold mask and the transfer request read back as zero, and all windows are disabled.
- R2: A write to a window field updates the shadow copy and nothing on the active outputs. A read returns the shadow value, with control bits above bit 3 reading zero.
- R3: Writing 1 to bit 0 of the transfer request register arms every window. The request reads 1 on the next cycle.
- R4: On a vsync edge, every armed window whose hold bit is 0 copies all its shadow fields into its active outputs in that one edge. The new values are visible the cycle after the pulse.
- R5: A window whose hold bit is 1 at vsync is not copied. It stays armed, and the transfer request keeps reading 1.
- R6: Once its hold bit is cleared, a still-armed window is copied at the next vsync with no new request.
- R7: The transfer request clears by itself once every armed window has been copied.
- R8: The active outputs do not change on any cycle without a vsync pulse. A vsync with no armed window leaves them unchanged.
- R9: Clearing a window's enable leaves the active enable at 1 until a vsync copies the window.
- R10: Writing 0 to the transfer request register has no effect.
- R11: When a shadow write and a vsync pulse fall in the same cycle, the active copy takes the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address, used for both writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| vsync | input | 1 | One-cycle vertical sync pulse |
| act_en | output | NUM_WIN | Active enable per window |
| act_fmt | output | NUM_WIN*3 | Active format codes, window w at [w*3 +: 3] |
| act_base | output | NUM_WIN*32 | Active base addresses, window w at [w*32 +: 32] |
| act_ofs | output | NUM_WIN*32 | Active offsets {y,x}, window w at [w*32 +: 32] |
| act_pos | output | NUM_WIN*32 | Active positions {y,x}, window w at [w*32 +: 32] |

## Verification
The bench builds the bank with the default of four windows, so the address is 5 bits wide. At that size, random addresses cover every window field and both global registers. Random hold masks often hold back some windows and release others on the same vsync. This exercises held windows that stay armed and partial transfers that keep the request set. The four windows also make it cheap to catch a copy that lands on the wrong window.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
    parameter int DATA_W = 32;
    parameter int FMT_W  = 3;
    parameter int CRD_W  = DATA_W / 2;
    localparam int CTRL_W = FMT_W + 1;

    typedef enum logic [1:0] {
        FLD_CTRL = 2'd0,
        FLD_BASE = 2'd1,
        FLD_OFS  = 2'd2,
        FLD_POS  = 2'd3
    } field_e;

    typedef struct packed {
        logic [CRD_W-1:0] y;
        logic [CRD_W-1:0] x;
    } xy_t;

    typedef struct packed {
        logic              en;
        logic [FMT_W-1:0]  fmt;
        logic [DATA_W-1:0] base;
        xy_t               ofs;
        xy_t               pos;
    } win_cfg_t;

    function automatic win_cfg_t apply_write(win_cfg_t cur, field_e f,
                                             logic [DATA_W-1:0] d);
        win_cfg_t nxt = cur;
        case (f)
            FLD_CTRL: begin
                nxt.en  = d[0];
                nxt.fmt = d[CTRL_W-1:1];
            end
            FLD_BASE: nxt.base = d;
            FLD_OFS:  nxt.ofs  = xy_t'(d);
            default:  nxt.pos  = xy_t'(d);
        endcase
        return nxt;
    endfunction

    function automatic logic [DATA_W-1:0] field_read(win_cfg_t c, field_e f);
        logic [DATA_W-1:0] r;
        case (f)
            FLD_CTRL: r = {{(DATA_W-CTRL_W){1'b0}}, c.fmt, c.en};
            FLD_BASE: r = c.base;
            FLD_OFS:  r = c.ofs;
            default:  r = c.pos;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/wsb_win.sv
module wsb_win
    import wsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  field_e            field,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output win_cfg_t          shadow,
    output win_cfg_t          active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr_en) shadow <= apply_write(shadow, field, wdata);
            if (load)  active <= shadow;
        end
    end
endmodule

// File: rtl/wsb_ctl.sv
module wsb_ctl #(
    parameter int NUM_WIN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vsync,
    input  logic               prot_wr,
    input  logic               upd_set,
    input  logic [NUM_WIN-1:0] prot_wdata,
    output logic [NUM_WIN-1:0] prot_q,
    output logic [NUM_WIN-1:0] arm_q,
    output logic [NUM_WIN-1:0] load
);
    always_comb load = vsync ? (arm_q & ~prot_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= '0;
            arm_q  <= '0;
        end else begin
            if (prot_wr) prot_q <= prot_wdata;
            arm_q <= (arm_q & ~load) | (upd_set ? {NUM_WIN{1'b1}} : '0);
        end
    end
endmodule

// File: rtl/wsb_bank.sv
module wsb_bank
    import wsb_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    input  logic                      vsync,
    output logic [NUM_WIN-1:0]        act_en,
    output logic [NUM_WIN*FMT_W-1:0]  act_fmt,
    output logic [NUM_WIN*DATA_W-1:0] act_base,
    output logic [NUM_WIN*DATA_W-1:0] act_ofs,
    output logic [NUM_WIN*DATA_W-1:0] act_pos
);
    logic             is_glb;
    logic [IDX_W-1:0] win_sel;
    field_e           field;
    logic             prot_wr;
    logic             upd_set;
    logic [NUM_WIN-1:0] prot_q;
    logic [NUM_WIN-1:0] arm_q;
    logic [NUM_WIN-1:0] load;
    win_cfg_t shadow [NUM_WIN];
    win_cfg_t active [NUM_WIN];

    always_comb begin
        is_glb  = addr[ADDR_W-1];
        win_sel = addr[IDX_W+1:2];
        field   = field_e'(addr[1:0]);
        prot_wr = wr_en && is_glb && !addr[0];
        upd_set = wr_en && is_glb && addr[0] && wdata[0];
    end

    wsb_ctl #(.NUM_WIN(NUM_WIN)) u_ctl (
        .clk(clk), .rst(rst), .vsync(vsync),
        .prot_wr(prot_wr), .upd_set(upd_set),
        .prot_wdata(wdata[NUM_WIN-1:0]),
        .prot_q(prot_q), .arm_q(arm_q), .load(load)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic win_wr;
        assign win_wr = wr_en && !is_glb && (win_sel == IDX_W'(w));
        wsb_win u_win (
            .clk(clk), .rst(rst), .wr_en(win_wr), .field(field),
            .wdata(wdata), .load(load[w]),
            .shadow(shadow[w]), .active(active[w])
        );
        assign act_en[w]                   = active[w].en;
        assign act_fmt[w*FMT_W +: FMT_W]   = active[w].fmt;
        assign act_base[w*DATA_W +: DATA_W] = active[w].base;
        assign act_ofs[w*DATA_W +: DATA_W]  = active[w].ofs;
        assign act_pos[w*DATA_W +: DATA_W]  = active[w].pos;
    end

    always_comb begin
        rdata = '0;
        if (is_glb) begin
            if (addr[0]) rdata[0] = |arm_q;
            else         rdata[NUM_WIN-1:0] = prot_q;
        end else begin
            for (int w = 0; w < NUM_WIN; w++)
                if (win_sel == IDX_W'(w)) rdata = field_read(shadow[w], field);
        end
    end
endmodule

// File: rtl/wsb_bank_chk.sv
module wsb_bank_chk #(
    parameter int NUM_WIN = 4,
    parameter int DATA_W  = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      vsync,
    input logic                      upd_set,
    input logic [NUM_WIN-1:0]        arm_q,
    input logic [NUM_WIN-1:0]        prot_q,
    input logic [NUM_WIN-1:0]        act_en,
    input logic [NUM_WIN*DATA_W-1:0] act_base
);
    // R1
    rst_clears_chk: assert property (@(posedge clk)
        rst |=> (act_en == '0 && act_base == '0 && arm_q == '0 && prot_q == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vsync |=> ($stable(act_en) && $stable(act_base)));

    // R5
    prot_keeps_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (vsync && !upd_set) |=> (arm_q == ($past(arm_q) & $past(prot_q))));

    // R7
    upd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (vsync && prot_q == '0 && !upd_set) |=> (arm_q == '0));

    // R3
    upd_arms_chk: assert property (@(posedge clk) disable iff (rst)
        upd_set |=> (&arm_q));
endmodule

bind wsb_bank wsb_bank_chk #(.NUM_WIN(NUM_WIN), .DATA_W(wsb_pkg::DATA_W)) u_chk (
    .clk(clk), .rst(rst), .vsync(vsync), .upd_set(upd_set),
    .arm_q(arm_q), .prot_q(prot_q), .act_en(act_en), .act_base(act_base)
);

// File: tb/wsb_bank_test.sv
module wsb_bank_test;
    localparam int NW = 4;
    localparam int AW = 5;

    logic clk = 0;
    logic rst = 1;
    logic wr_en = 0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic vsync = 0;
    logic [NW-1:0] act_en;
    logic [NW*3-1:0] act_fmt;
    logic [NW*32-1:0] act_base, act_ofs, act_pos;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_sh [NW][4];
    logic [31:0] m_ac [NW][4];
    logic [NW-1:0] m_arm = '0;
    logic [NW-1:0] m_prot = '0;

    always #4 clk = ~clk;

    wsb_bank #(.NUM_WIN(NW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .vsync(vsync), .act_en(act_en), .act_fmt(act_fmt),
        .act_base(act_base), .act_ofs(act_ofs), .act_pos(act_pos)
    );

    function automatic logic [31:0] m_read(logic [AW-1:0] a);
        if (a[AW-1]) return a[0] ? {31'b0, |m_arm} : {{(32-NW){1'b0}}, m_prot};
        return m_sh[a[3:2]][a[1:0]];
    endfunction

    function automatic logic [NW*100-1:0] m_outs();
        logic [NW*100-1:0] v = '0;
        for (int w = 0; w < NW; w++)
            v[w*100 +: 100] = {m_ac[w][0][3:0], m_ac[w][1], m_ac[w][2], m_ac[w][3]};
        return v;
    endfunction

    function automatic logic [NW*100-1:0] dut_outs();
        logic [NW*100-1:0] v = '0;
        for (int w = 0; w < NW; w++)
            v[w*100 +: 100] = {act_fmt[w*3 +: 3], act_en[w], act_base[w*32 +: 32],
                               act_ofs[w*32 +: 32], act_pos[w*32 +: 32]};
        return v;
    endfunction

    // drive at a falling edge, model the rising edge, return idle at the next falling edge
    task automatic step(input logic we, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic vs);
        logic [NW-1:0] ld;
        wr_en = we; addr = a; wdata = d; vsync = vs;
        @(posedge clk);
        ld = vs ? (m_arm & ~m_prot) : '0;
        for (int w = 0; w < NW; w++)
            if (ld[w]) for (int f = 0; f < 4; f++) m_ac[w][f] = m_sh[w][f];
        m_arm = m_arm & ~ld;
        if (we) begin
            if (!a[AW-1]) m_sh[a[3:2]][a[1:0]] = (a[1:0] == 2'd0) ? (d & 32'hF) : d;
            else if (!a[0]) m_prot = d[NW-1:0];
            else if (d[0]) m_arm = '1;
        end
        @(negedge clk);
        wr_en = 0; vsync = 0;
    endtask

    task automatic chk_outs(input string tag);
        logic [NW*100-1:0] got, exp;
        #1;
        got = dut_outs(); exp = m_outs();
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s active outputs got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic chk_rd(input logic [AW-1:0] a, input string tag);
        addr = a;
        #1;
        n_tests++;
        if (rdata !== m_read(a)) begin
            n_fail++;
            $display("FAIL %s read addr %0d got %h exp %h", tag, a, rdata, m_read(a));
        end
    endtask

    task automatic chk_val(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    localparam logic [AW-1:0] A_PROT = 5'd16;
    localparam logic [AW-1:0] A_UPD  = 5'd17;

    function automatic logic [AW-1:0] wa(int w, int f);
        return AW'(w * 4 + f);
    endfunction

    initial begin
        for (int w = 0; w < NW; w++)
            for (int f = 0; f < 4; f++) begin m_sh[w][f] = '0; m_ac[w][f] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        chk_outs("R1");
        chk_rd(A_PROT, "R1");
        chk_rd(A_UPD, "R1");
        chk_rd(wa(2, 0), "R1");

        // R2: shadow writes only
        step(1, wa(1, 0), 32'hFFFF_FFF7, 0);
        step(1, wa(1, 1), 32'h1000_0000, 0);
        step(1, wa(1, 2), 32'h0020_0010, 0);
        step(1, wa(1, 3), 32'h0100_0080, 0);
        chk_outs("R2");
        chk_rd(wa(1, 0), "R2");
        chk_val(rdata, 32'h7, "R2 ctrl upper bits");
        chk_rd(wa(1, 1), "R2");

        // R8: vsync without request
        step(0, '0, '0, 1);
        chk_outs("R8");

        // R10: writing 0 to request
        step(1, A_UPD, 32'hFFFF_FFFE, 0);
        chk_rd(A_UPD, "R10");
        chk_val(rdata, 32'h0, "R10 request stays clear");

        // R3 and R4
        step(1, A_UPD, 32'h1, 0);
        chk_rd(A_UPD, "R3");
        chk_val(rdata, 32'h1, "R3 request set");
        step(0, '0, '0, 1);
        chk_outs("R4");
        chk_val({31'b0, act_en[1]}, 32'h1, "R4 window 1 enabled");
        chk_rd(A_UPD, "R7");
        chk_val(rdata, 32'h0, "R7 request cleared");

        // R5: hold window 2
        step(1, A_PROT, 32'h4, 0);
        step(1, wa(2, 1), 32'hABCD_0000, 0);
        step(1, wa(2, 0), 32'h5, 0);
        step(1, wa(0, 1), 32'h2222_0000, 0);
        step(1, A_UPD, 32'h1, 0);
        step(0, '0, '0, 1);
        chk_outs("R5");
        chk_val(act_base[2*32 +: 32], 32'h0, "R5 held window not copied");
        chk_val(act_base[0 +: 32], 32'h2222_0000, "R5 free window copied");
        chk_rd(A_UPD, "R5");
        chk_val(rdata, 32'h1, "R5 request still set");

        // R6: release and copy without new request
        step(1, A_PROT, 32'h0, 0);
        chk_outs("R6");
        step(0, '0, '0, 1);
        chk_outs("R6");
        chk_val(act_base[2*32 +: 32], 32'hABCD_0000, "R6 released window copied");
        chk_rd(A_UPD, "R7");

        // R9: enable clear waits for vsync
        step(1, wa(1, 0), 32'h0, 0);
        step(1, A_UPD, 32'h1, 0);
        chk_val({31'b0, act_en[1]}, 32'h1, "R9 enable held before vsync");
        step(0, '0, '0, 1);
        chk_val({31'b0, act_en[1]}, 32'h0, "R9 enable cleared at vsync");
        chk_outs("R9");

        // R11: write and vsync in the same cycle
        step(1, wa(3, 1), 32'h3333_0000, 0);
        step(1, A_UPD, 32'h1, 0);
        step(1, wa(3, 1), 32'h4444_0000, 1);
        chk_val(act_base[3*32 +: 32], 32'h3333_0000, "R11 pre-write value copied");
        chk_outs("R11");

        // random traffic against the model
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            logic we;
            logic [AW-1:0] a;
            logic [31:0] d;
            logic vs;
            we = ($urandom % 2) == 0;
            a  = AW'($urandom % 32);
            if (($urandom % 6) == 0) a = A_UPD;
            if (($urandom % 8) == 0) a = A_PROT;
            d  = $urandom;
            vs = ($urandom % 6) == 0;
            step(we, a, d, vs);
            chk_outs("R4");
            if ((i % 5) == 0) chk_rd(AW'($urandom % 32), "R2");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule